// File: doc/BRIEF.md
# Instruction Control Decoder with Upper-Immediate Load

This block turns the fields of a 32-bit RISC-V instruction word into the control bits a five-stage integer pipeline needs in its decode stage. It is purely combinational. A primary decoder looks only at the 7-bit opcode. It sets the register-file write enable, the immediate format, the second-operand select, the store enable, the writeback source, and the branch and jump flags, and it passes a two-bit operation class to a secondary decoder.

The secondary decoder combines that class with funct3, bit 5 of funct7 and bit 5 of the opcode to pick a 3-bit ALU operation code. The decoder handles loads, stores, register-register and register-immediate arithmetic, branch-if-equal and jump-and-link. It also handles the U-type instruction that loads a 20-bit constant into the upper bits of a register.

For that instruction the decoder raises a dedicated flag. The datapath uses this flag to shift the immediate and to bypass the ALU operands. The decoder also selects an ALU code reserved for the pass-through. The low bits of that instruction word belong to the constant, so the flag takes priority over any funct3-based choice.

Top module: `rv_ctrl_decoder`

## Requirements
- R1: `lui_o` is 1 when `opcode_i` = 7'b0110111, and 0 for every other opcode.
- R2: For opcode 7'b0110111 the outputs are: reg_write=1, imm_src=00, alu_src=1, mem_write=0, result_src=00 (ALU result), branch=0, jump=0.
- R3: For opcode 7'b0110111, `alu_ctrl_o` = 3'b110 for every value of funct3 and funct7 bit 5.
- R4: A load (opcode 7'b0000011) gives reg_write=1, imm_src=00, alu_src=1, mem_write=0, result_src=01 (memory data), branch=0, jump=0, alu_ctrl=000 (add).
- R5: A store (opcode 7'b0100011) gives reg_write=0, imm_src=01, alu_src=1, mem_write=1, result_src=00, branch=0, jump=0, alu_ctrl=000.
- R6: A register-register op (opcode 7'b0110011) gives reg_write=1, imm_src=00, alu_src=0, result_src=00, mem_write=0. With funct3=000, alu_ctrl is 001 (subtract) when funct7 bit 5 is 1, and 000 (add) when it is 0.
- R7: A register-immediate op (opcode 7'b0010011) gives reg_write=1, imm_src=00, alu_src=1, result_src=00. With funct3=000, alu_ctrl is always 000, whatever funct7 bit 5 is.
- R8: For both arithmetic opcodes, funct3=010 gives alu_ctrl 101 (set-less-than), 110 gives 011 (or), and 111 gives 010 (and). Any other funct3 except 000 gives 000.
- R9: Branch-if-equal (opcode 7'b1100011) gives reg_write=0, imm_src=10, alu_src=0, mem_write=0, branch=1, jump=0, result_src=00, alu_ctrl=001 (subtract).
- R10: Jump-and-link (opcode 7'b1101111) gives reg_write=1, imm_src=11, alu_src=0, mem_write=0, result_src=10 (PC+4), branch=0, jump=1, alu_ctrl=000.
- R11: Any other opcode drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 7 | Instruction bits 6:0 |
| funct3_i | input | 3 | Instruction bits 14:12 |
| funct7b5_i | input | 1 | Instruction bit 30 |
| reg_write_o | output | 1 | Register-file write enable |
| imm_src_o | output | 2 | Immediate format: 00 I, 01 S, 10 B, 11 J |
| alu_src_o | output | 1 | ALU operand B: 0 register, 1 immediate |
| mem_write_o | output | 1 | Data-memory write enable |
| result_src_o | output | 2 | Writeback: 00 ALU, 01 memory, 10 PC+4 |
| branch_o | output | 1 | Conditional branch instruction |
| jump_o | output | 1 | Unconditional jump instruction |
| alu_ctrl_o | output | 3 | ALU operation code |
| lui_o | output | 1 | Upper-immediate load flag |

## Verification
The block holds no state, so a wrong table entry shows up at the ports in the same cycle as the opcode that selects it. A wrong entry would be a miscoded row, or a class-to-function mapping that lets funct3 override the upper-immediate flag. Exercising every supported opcode against all eight funct3 values and both funct7 bit-5 values exposes any entry that leaks between instruction classes. Unknown opcodes show whether a stray write enable stays raised, which in a real pipeline would corrupt architectural state.

// File: rtl/rv_ctrl_pkg.sv
package rv_ctrl_pkg;
  localparam int OPC_W  = 7;
  localparam int F3_W   = 3;
  localparam int ALUC_W = 3;
  localparam int IMMS_W = 2;
  localparam int RES_W  = 2;
  localparam int CLS_W  = 2;

  localparam logic [OPC_W-1:0] OPC_LOAD  = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_STORE = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_RREG  = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_RIMM  = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_JAL   = 7'b1101111;
  localparam logic [OPC_W-1:0] OPC_UPIMM = 7'b0110111;

  typedef enum logic [CLS_W-1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FUNCT = 2'b10,
    CLS_RSVD  = 2'b11
  } op_class_e;

  typedef enum logic [ALUC_W-1:0] {
    ALU_ADD  = 3'b000,
    ALU_SUB  = 3'b001,
    ALU_AND  = 3'b010,
    ALU_OR   = 3'b011,
    ALU_SLT  = 3'b101,
    ALU_PASS = 3'b110
  } alu_op_e;

  typedef struct packed {
    logic              reg_write;
    logic [IMMS_W-1:0] imm_src;
    logic              alu_src;
    logic              mem_write;
    logic [RES_W-1:0]  result_src;
    logic              branch;
    logic              jump;
    logic              upimm;
    op_class_e         op_class;
  } main_ctrl_t;
endpackage

// File: rtl/rv_main_dec.sv
module rv_main_dec
  import rv_ctrl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output main_ctrl_t       ctrl_o
);
  always_comb begin
    ctrl_o = '{default: '0, op_class: CLS_ADD};
    case (opcode_i)
      OPC_LOAD: begin
        ctrl_o.reg_write  = 1'b1;
        ctrl_o.alu_src    = 1'b1;
        ctrl_o.result_src = 2'b01;
      end
      OPC_STORE: begin
        ctrl_o.imm_src    = 2'b01;
        ctrl_o.alu_src    = 1'b1;
        ctrl_o.mem_write  = 1'b1;
      end
      OPC_RREG: begin
        ctrl_o.reg_write  = 1'b1;
        ctrl_o.op_class   = CLS_FUNCT;
      end
      OPC_RIMM: begin
        ctrl_o.reg_write  = 1'b1;
        ctrl_o.alu_src    = 1'b1;
        ctrl_o.op_class   = CLS_FUNCT;
      end
      OPC_BEQ: begin
        ctrl_o.imm_src    = 2'b10;
        ctrl_o.branch     = 1'b1;
        ctrl_o.op_class   = CLS_SUB;
      end
      OPC_JAL: begin
        ctrl_o.reg_write  = 1'b1;
        ctrl_o.imm_src    = 2'b11;
        ctrl_o.result_src = 2'b10;
        ctrl_o.jump       = 1'b1;
      end
      OPC_UPIMM: begin
        ctrl_o.reg_write  = 1'b1;
        ctrl_o.alu_src    = 1'b1;
        ctrl_o.upimm      = 1'b1;
        ctrl_o.op_class   = CLS_FUNCT;
      end
      default: ctrl_o = '{default: '0, op_class: CLS_ADD};
    endcase
  end
endmodule

// File: rtl/rv_alu_dec.sv
module rv_alu_dec
  import rv_ctrl_pkg::*;
(
  input  op_class_e         op_class_i,
  input  logic              upimm_i,
  input  logic              opc_b5_i,
  input  logic [F3_W-1:0]   funct3_i,
  input  logic              funct7b5_i,
  output logic [ALUC_W-1:0] alu_ctrl_o
);
  logic sub_sel;
  assign sub_sel = opc_b5_i & funct7b5_i;

  always_comb begin
    alu_ctrl_o = ALU_ADD;
    case (op_class_i)
      CLS_ADD: alu_ctrl_o = ALU_ADD;
      CLS_SUB: alu_ctrl_o = ALU_SUB;
      CLS_FUNCT: begin
        if (upimm_i) begin
          alu_ctrl_o = ALU_PASS;
        end else begin
          case (funct3_i)
            3'b000:  alu_ctrl_o = sub_sel ? ALU_SUB : ALU_ADD;
            3'b010:  alu_ctrl_o = ALU_SLT;
            3'b110:  alu_ctrl_o = ALU_OR;
            3'b111:  alu_ctrl_o = ALU_AND;
            default: alu_ctrl_o = ALU_ADD;
          endcase
        end
      end
      default: alu_ctrl_o = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/rv_ctrl_decoder.sv
module rv_ctrl_decoder
  import rv_ctrl_pkg::*;
(
  input  logic [6:0] opcode_i,
  input  logic [2:0] funct3_i,
  input  logic       funct7b5_i,
  output logic       reg_write_o,
  output logic [1:0] imm_src_o,
  output logic       alu_src_o,
  output logic       mem_write_o,
  output logic [1:0] result_src_o,
  output logic       branch_o,
  output logic       jump_o,
  output logic [2:0] alu_ctrl_o,
  output logic       lui_o
);
  main_ctrl_t main_ctrl;

  rv_main_dec u_main (
    .opcode_i (opcode_i),
    .ctrl_o   (main_ctrl)
  );

  rv_alu_dec u_alu (
    .op_class_i (main_ctrl.op_class),
    .upimm_i    (main_ctrl.upimm),
    .opc_b5_i   (opcode_i[5]),
    .funct3_i   (funct3_i),
    .funct7b5_i (funct7b5_i),
    .alu_ctrl_o (alu_ctrl_o)
  );

  assign reg_write_o  = main_ctrl.reg_write;
  assign imm_src_o    = main_ctrl.imm_src;
  assign alu_src_o    = main_ctrl.alu_src;
  assign mem_write_o  = main_ctrl.mem_write;
  assign result_src_o = main_ctrl.result_src;
  assign branch_o     = main_ctrl.branch;
  assign jump_o       = main_ctrl.jump;
  assign lui_o        = main_ctrl.upimm;
endmodule

// File: rtl/rv_ctrl_decoder_chk.sv
module rv_ctrl_decoder_chk (
  input logic [6:0] opcode_i,
  input logic [2:0] funct3_i,
  input logic       funct7b5_i,
  input logic       reg_write_o,
  input logic [1:0] imm_src_o,
  input logic       alu_src_o,
  input logic       mem_write_o,
  input logic [1:0] result_src_o,
  input logic       branch_o,
  input logic       jump_o,
  input logic [2:0] alu_ctrl_o,
  input logic       lui_o
);
  always_comb begin
    if (!$isunknown({opcode_i, funct3_i, funct7b5_i})) begin
      a_r3_lui_pass_code: assert (!lui_o || alu_ctrl_o == 3'b110);
      a_r2_lui_writes_reg: assert (!lui_o || (reg_write_o && alu_src_o && !mem_write_o
                                   && result_src_o == 2'b00 && imm_src_o == 2'b00));
      a_r1_lui_exclusive: assert ($onehot0({lui_o, branch_o, jump_o, mem_write_o}));
      a_r9_branch_subtracts: assert (!branch_o || (alu_ctrl_o == 3'b001 && !reg_write_o));
      a_r10_jump_links: assert (!jump_o || (result_src_o == 2'b10 && reg_write_o));
      a_r5_store_no_write: assert (!mem_write_o || !reg_write_o);
    end
  end
endmodule

bind rv_ctrl_decoder rv_ctrl_decoder_chk u_chk (
  .opcode_i     (opcode_i),
  .funct3_i     (funct3_i),
  .funct7b5_i   (funct7b5_i),
  .reg_write_o  (reg_write_o),
  .imm_src_o    (imm_src_o),
  .alu_src_o    (alu_src_o),
  .mem_write_o  (mem_write_o),
  .result_src_o (result_src_o),
  .branch_o     (branch_o),
  .jump_o       (jump_o),
  .alu_ctrl_o   (alu_ctrl_o),
  .lui_o        (lui_o)
);

// File: tb/sim_rv_ctrl_decoder.sv
module sim_rv_ctrl_decoder;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 5000;

  logic       clk;
  logic       rst_n;
  logic [6:0] opcode;
  logic [2:0] funct3;
  logic       f7b5;
  logic       reg_write, alu_src, mem_write, branch, jump, lui;
  logic [1:0] imm_src, result_src;
  logic [2:0] alu_ctrl;

  typedef struct {
    logic [12:0] exp;
    string       req;
    logic [6:0]  op;
    logic [2:0]  f3;
    logic        f7;
  } item_t;

  item_t sb_q[$];
  int    checks = 0;
  int    fails  = 0;
  bit    drv_done = 1'b0;

  rv_ctrl_decoder u0 (
    .opcode_i     (opcode),
    .funct3_i     (funct3),
    .funct7b5_i   (f7b5),
    .reg_write_o  (reg_write),
    .imm_src_o    (imm_src),
    .alu_src_o    (alu_src),
    .mem_write_o  (mem_write),
    .result_src_o (result_src),
    .branch_o     (branch),
    .jump_o       (jump),
    .alu_ctrl_o   (alu_ctrl),
    .lui_o        (lui)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Vector order: reg_write, imm_src, alu_src, mem_write, result_src, branch, jump, alu_ctrl, lui
  function automatic logic [12:0] pack(logic rw, logic [1:0] is, logic as, logic mw,
                                       logic [1:0] rs, logic br, logic jp,
                                       logic [2:0] ac, logic lu);
    return {rw, is, as, mw, rs, br, jp, ac, lu};
  endfunction

  function automatic logic [2:0] funct_code(logic [2:0] f3, logic sub_ok);
    case (f3)
      3'b000:  return sub_ok ? 3'b001 : 3'b000;   // R6 / R7
      3'b010:  return 3'b101;                      // R8
      3'b110:  return 3'b011;
      3'b111:  return 3'b010;
      default: return 3'b000;
    endcase
  endfunction

  function automatic item_t model(logic [6:0] op, logic [2:0] f3, logic f7);
    item_t it;
    it.op = op; it.f3 = f3; it.f7 = f7;
    case (op)
      7'b0110111: begin it.exp = pack(1, 2'b00, 1, 0, 2'b00, 0, 0, 3'b110, 1); it.req = "R1/R2/R3"; end
      7'b0000011: begin it.exp = pack(1, 2'b00, 1, 0, 2'b01, 0, 0, 3'b000, 0); it.req = "R4"; end
      7'b0100011: begin it.exp = pack(0, 2'b01, 1, 1, 2'b00, 0, 0, 3'b000, 0); it.req = "R5"; end
      7'b0110011: begin it.exp = pack(1, 2'b00, 0, 0, 2'b00, 0, 0, funct_code(f3, f7), 0); it.req = "R6/R8"; end
      7'b0010011: begin it.exp = pack(1, 2'b00, 1, 0, 2'b00, 0, 0, funct_code(f3, 1'b0), 0); it.req = "R7/R8"; end
      7'b1100011: begin it.exp = pack(0, 2'b10, 0, 0, 2'b00, 1, 0, 3'b001, 0); it.req = "R9"; end
      7'b1101111: begin it.exp = pack(1, 2'b11, 0, 0, 2'b10, 0, 1, 3'b000, 0); it.req = "R10"; end
      default:    begin it.exp = '0; it.req = "R11/R1"; end
    endcase
    return it;
  endfunction

  task automatic drive(logic [6:0] op, logic [2:0] f3, logic f7);
    @(posedge clk);
    opcode = op; funct3 = f3; f7b5 = f7;
    sb_q.push_back(model(op, f3, f7));
  endtask

  // Monitor: compares at the falling edge after the inputs settle
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [12:0] act;
      it  = sb_q.pop_front();
      act = {reg_write, imm_src, alu_src, mem_write, result_src, branch, jump, alu_ctrl, lui};
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s op=%b f3=%b f7b5=%b actual=%h expected=%h",
                 it.req, it.op, it.f3, it.f7, act, it.exp);
      end
    end
  end

  initial begin
    rst_n  = 1'b0;
    opcode = 7'b0000000; funct3 = 3'b000; f7b5 = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R11: initial all-zero opcode leaves every output at 0
    drive(7'b0000000, 3'b000, 1'b0);
    // R1 R2 R3: upper-immediate load with every funct3 and funct7 bit 5
    for (int f = 0; f < 8; f++) begin
      drive(7'b0110111, 3'(f), 1'b0);
      drive(7'b0110111, 3'(f), 1'b1);
    end
    // R4 R5 R9 R10
    for (int f = 0; f < 8; f += 3) begin
      drive(7'b0000011, 3'(f), 1'b0);
      drive(7'b0100011, 3'(f), 1'b1);
      drive(7'b1100011, 3'(f), 1'b0);
      drive(7'b1101111, 3'(f), 1'b1);
    end
    // R6 R7 R8: both arithmetic opcodes with every funct3 and funct7 bit 5
    for (int f = 0; f < 8; f++) begin
      for (int s = 0; s < 2; s++) begin
        drive(7'b0110011, 3'(f), 1'(s));
        drive(7'b0010011, 3'(f), 1'(s));
      end
    end
    // R11 R1: unknown opcodes, including neighbours of the upper-immediate opcode
    drive(7'b0010111, 3'b000, 1'b1);
    drive(7'b0110110, 3'b010, 1'b0);
    drive(7'b1110111, 3'b111, 1'b1);
    drive(7'b1100111, 3'b000, 1'b0);
    drive(7'b1111111, 3'b110, 1'b1);
    drive(7'b0100111, 3'b001, 1'b0);
    // Back-to-back upper-immediate after a register-register subtract (R3 R6)
    drive(7'b0110011, 3'b000, 1'b1);
    drive(7'b0110111, 3'b000, 1'b1);
    drive(7'b0110111, 3'b010, 1'b0);
    repeat (3) @(posedge clk);
    drv_done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!drv_done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!drv_done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule